// File: doc/BRIEF.md
# Priority Pin Crossbar Allocator

This block connects a fixed set of digital peripheral signals to a bank of general-purpose pins. The pins are grouped as four 8-bit ports, so flat pin index p is port p/8, bit p%8. Four 8-bit configuration bytes hold per-peripheral enable bits and a 3-bit count of timer/PCA compare outputs. A separate input selects 3-wire SPI operation.

Pin positions are not fixed. The block walks the functions from highest to lowest priority. Each enabled function takes the next free pin, starting at pin 0, so every combination of enables produces its own pinout. A serial peripheral always claims all of its signals together. Claimed pins carry the peripheral's output value and output enable. Pin input values are routed back to the peripheral that owns the pin. Unclaimed pins stay general-purpose I/O, driven from the port data inputs.

The configuration is captured in a register on each clock. Allocation and all muxing then follow combinationally from that registered copy.

Top module: `pin_xbar`

## Requirements
- R1: Function priority, highest first, is: TX0, RX0, SCK, MISO, MOSI, NSS, SDA, SCL, TX1, RX1, CEX0..CEX5, ECI, CP0, CP1, CP2, T0, INT0, T1, INT1, T2, T2EX, T3, T3EX, T4, T4EX, SYSCLK, CNVSTR0, CNVSTR2. Enabled functions occupy consecutive pins from pin 0 in that order.
- R2: When the UART0 enable is set, pin 0 carries TX0 and pin 1 carries RX0, whatever else is enabled.
- R3: A single enable places all signals of a serial peripheral together: UART0 (TX0, RX0), SPI (SCK, MISO, MOSI, NSS), SMBus (SDA, SCL) and UART1 (TX1, RX1).
- R4: With spi_3wire_i high, NSS gets no pin and every later function moves down one pin.
- R5: Enable bits by configuration byte:
  - cfg0: bit0 SMBus, bit1 SPI, bit2 UART0, bit6 ECI, bit7 CP0.
  - cfg1: bit0 CP1, bit1 T0, bit2 INT0, bit3 T1, bit4 INT1, bit5 T2, bit6 T2EX, bit7 SYSCLK.
  - cfg2: bit0 CNVSTR0, bit2 UART1, bit3 T4, bit4 T4EX.
  - cfg3: bit0 T3, bit1 T3EX, bit2 CNVSTR2, bit3 CP2.
  - All other bits are ignored.
- R6: cfg0[5:3] sets how many of CEX0..CEX5 are placed, taken from CEX0 upward. The value 7 is treated as 6.
- R7: A function that is not enabled holds no pin, and its peripheral input reads 1.
- R8: On a pin with code 0, pin_out_o and pin_oe_o equal gpio_out_i and gpio_oe_i. gpio_in_o always equals pad_in_i.
- R9: On a claimed pin, pin_out_o and pin_oe_o come from that function's periph_out_i and periph_oe_i. For input-only functions the output enable is forced low. The input-only functions are RX0, RX1, ECI, T0, INT0, T1, INT1, T2, T2EX, T3, T3EX, T4, T4EX, CNVSTR0 and CNVSTR2.
- R10: periph_in_o of a placed function equals pad_in_i at its pin.
- R11: A function whose position would be NUM_PINS or beyond is not placed, and its input reads 1. With all enables set and 32 pins, CNVSTR2 is the one function left out.
- R12: pin_code_o gives one 6-bit code per pin: 0 for GPIO, otherwise 1 + the function's R1 priority index. TX0=1, RX0=2, SCK=3, NSS=6, SDA=7, TX1=9, CEX0=11, ECI=17, CP0=18, T0=21, SYSCLK=31, CNVSTR0=32, CNVSTR2=33.
- R13: Reset clears the registered configuration, so every pin is GPIO. A new configuration takes effect on the outputs after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg0_i | input | 8 | Configuration byte 0 |
| cfg1_i | input | 8 | Configuration byte 1 |
| cfg2_i | input | 8 | Configuration byte 2 |
| cfg3_i | input | 8 | Configuration byte 3 |
| spi_3wire_i | input | 1 | SPI 3-wire mode, drops NSS |
| pad_in_i | input | NUM_PINS | Pin input levels |
| gpio_out_i | input | NUM_PINS | Port data output values |
| gpio_oe_i | input | NUM_PINS | Port data output enables |
| gpio_in_o | output | NUM_PINS | Port data read values |
| periph_out_i | input | 33 | Peripheral output value per function |
| periph_oe_i | input | 33 | Peripheral output enable per function |
| periph_in_o | output | 33 | Routed input per function |
| pin_out_o | output | NUM_PINS | Pin output value |
| pin_oe_o | output | NUM_PINS | Pin output enable |
| pin_code_o | output | NUM_PINS x 6 | Per-pin function code |

## Verification
The bench builds two copies of the block. One uses the default of 32 pins. The other sets NUM_PINS to 24, so that moderate enable sets already run past the last pin and the overflow path (R11) is reached without enabling everything. The 32-pin copy covers the full pinout, including the single leftover function when every enable is set. Both copies are compared pin by pin against an independent priority walk over table and random configurations.

// File: rtl/pin_xbar_pkg.sv
package pin_xbar_pkg;
  localparam int NUM_FUNCS = 33;
  localparam int CODE_W    = $clog2(NUM_FUNCS + 1);
  localparam int PCA_MAX   = 6;

  // priority index of each function
  localparam int F_TX0  = 0;
  localparam int F_RX0  = 1;
  localparam int F_SCK  = 2;
  localparam int F_MISO = 3;
  localparam int F_MOSI = 4;
  localparam int F_NSS  = 5;
  localparam int F_SDA  = 6;
  localparam int F_SCL  = 7;
  localparam int F_TX1  = 8;
  localparam int F_RX1  = 9;
  localparam int F_CEX0 = 10;
  localparam int F_ECI  = 16;
  localparam int F_CP0  = 17;
  localparam int F_CP1  = 18;
  localparam int F_CP2  = 19;
  localparam int F_T0   = 20;
  localparam int F_INT0 = 21;
  localparam int F_T1   = 22;
  localparam int F_INT1 = 23;
  localparam int F_T2   = 24;
  localparam int F_T2X  = 25;
  localparam int F_T3   = 26;
  localparam int F_T3X  = 27;
  localparam int F_T4   = 28;
  localparam int F_T4X  = 29;
  localparam int F_SCLK = 30;
  localparam int F_CNV0 = 31;
  localparam int F_CNV2 = 32;

  typedef logic [NUM_FUNCS-1:0] func_vec_t;
  typedef logic [CODE_W-1:0]    code_t;

  function automatic func_vec_t input_only_mask();
    func_vec_t m;
    m = '0;
    m[F_RX0]  = 1'b1;
    m[F_RX1]  = 1'b1;
    m[F_ECI]  = 1'b1;
    for (int f = F_T0; f <= F_T4X; f++) m[f] = 1'b1;
    m[F_CNV0] = 1'b1;
    m[F_CNV2] = 1'b1;
    return m;
  endfunction

  localparam func_vec_t INPUT_ONLY = input_only_mask();
endpackage

// File: rtl/pin_xbar_enable_decode.sv
module pin_xbar_enable_decode
  import pin_xbar_pkg::*;
(
  input  logic [7:0] cfg0_i,
  input  logic [7:0] cfg1_i,
  input  logic [7:0] cfg2_i,
  input  logic [7:0] cfg3_i,
  input  logic       three_wire_i,
  output func_vec_t  en_o
);
  logic unused_cfg_bits;
  assign unused_cfg_bits = ^{cfg2_i[7:5], cfg2_i[1], cfg3_i[7:4]};

  always_comb begin
    en_o = '0;
    en_o[F_TX0]  = cfg0_i[2];
    en_o[F_RX0]  = cfg0_i[2];
    en_o[F_SCK]  = cfg0_i[1];
    en_o[F_MISO] = cfg0_i[1];
    en_o[F_MOSI] = cfg0_i[1];
    en_o[F_NSS]  = cfg0_i[1] & ~three_wire_i;
    en_o[F_SDA]  = cfg0_i[0];
    en_o[F_SCL]  = cfg0_i[0];
    en_o[F_TX1]  = cfg2_i[2];
    en_o[F_RX1]  = cfg2_i[2];
    // count above PCA_MAX saturates naturally
    for (int k = 0; k < PCA_MAX; k++)
      en_o[F_CEX0+k] = (int'(cfg0_i[5:3]) > k);
    en_o[F_ECI]  = cfg0_i[6];
    en_o[F_CP0]  = cfg0_i[7];
    en_o[F_CP1]  = cfg1_i[0];
    en_o[F_CP2]  = cfg3_i[3];
    en_o[F_T0]   = cfg1_i[1];
    en_o[F_INT0] = cfg1_i[2];
    en_o[F_T1]   = cfg1_i[3];
    en_o[F_INT1] = cfg1_i[4];
    en_o[F_T2]   = cfg1_i[5];
    en_o[F_T2X]  = cfg1_i[6];
    en_o[F_T3]   = cfg3_i[0];
    en_o[F_T3X]  = cfg3_i[1];
    en_o[F_T4]   = cfg2_i[3];
    en_o[F_T4X]  = cfg2_i[4];
    en_o[F_SCLK] = cfg1_i[7];
    en_o[F_CNV0] = cfg2_i[0];
    en_o[F_CNV2] = cfg3_i[2];
  end
endmodule

// File: rtl/pin_xbar_alloc.sv
module pin_xbar_alloc
  import pin_xbar_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  func_vec_t                   en_i,
  output logic [NUM_PINS-1:0][CODE_W-1:0] pin_code_o
);
  localparam int POS_W = $clog2(NUM_FUNCS + 1);

  logic [NUM_FUNCS-1:0][POS_W-1:0] pos;
  func_vec_t                       placed;

  // prefix count over enables in priority order
  always_comb begin
    logic [POS_W-1:0] run;
    run = '0;
    for (int f = 0; f < NUM_FUNCS; f++) begin
      pos[f]    = run;
      placed[f] = en_i[f] && (int'(pos[f]) < NUM_PINS);
      run       = run + POS_W'(en_i[f]);
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    always_comb begin
      pin_code_o[p] = '0;
      for (int f = 0; f < NUM_FUNCS; f++)
        if (placed[f] && int'(pos[f]) == p) pin_code_o[p] = CODE_W'(f + 1);
    end
  end
endmodule

// File: rtl/pin_xbar_route.sv
module pin_xbar_route
  import pin_xbar_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic [NUM_PINS-1:0][CODE_W-1:0] pin_code_i,
  input  logic [NUM_PINS-1:0]             pad_in_i,
  input  logic [NUM_PINS-1:0]             gpio_out_i,
  input  logic [NUM_PINS-1:0]             gpio_oe_i,
  input  func_vec_t                       periph_out_i,
  input  func_vec_t                       periph_oe_i,
  output logic [NUM_PINS-1:0]             pin_out_o,
  output logic [NUM_PINS-1:0]             pin_oe_o,
  output func_vec_t                       periph_in_o
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_out
    always_comb begin
      pin_out_o[p] = gpio_out_i[p];
      pin_oe_o[p]  = gpio_oe_i[p];
      for (int f = 0; f < NUM_FUNCS; f++)
        if (pin_code_i[p] == CODE_W'(f + 1)) begin
          pin_out_o[p] = periph_out_i[f];
          pin_oe_o[p]  = periph_oe_i[f] & ~INPUT_ONLY[f];
        end
    end
  end

  // unplaced inputs idle high
  for (genvar f = 0; f < NUM_FUNCS; f++) begin : g_in
    always_comb begin
      periph_in_o[f] = 1'b1;
      for (int p = 0; p < NUM_PINS; p++)
        if (pin_code_i[p] == CODE_W'(f + 1)) periph_in_o[f] = pad_in_i[p];
    end
  end
endmodule

// File: rtl/pin_xbar.sv
module pin_xbar
  import pin_xbar_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [7:0]                      cfg0_i,
  input  logic [7:0]                      cfg1_i,
  input  logic [7:0]                      cfg2_i,
  input  logic [7:0]                      cfg3_i,
  input  logic                            spi_3wire_i,
  input  logic [NUM_PINS-1:0]             pad_in_i,
  input  logic [NUM_PINS-1:0]             gpio_out_i,
  input  logic [NUM_PINS-1:0]             gpio_oe_i,
  output logic [NUM_PINS-1:0]             gpio_in_o,
  input  logic [NUM_FUNCS-1:0]            periph_out_i,
  input  logic [NUM_FUNCS-1:0]            periph_oe_i,
  output logic [NUM_FUNCS-1:0]            periph_in_o,
  output logic [NUM_PINS-1:0]             pin_out_o,
  output logic [NUM_PINS-1:0]             pin_oe_o,
  output logic [NUM_PINS-1:0][CODE_W-1:0] pin_code_o
);
  logic [3:0][7:0] cfg_q;
  logic            three_wire_q;
  func_vec_t       en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q        <= '0;
      three_wire_q <= 1'b0;
    end else begin
      cfg_q        <= {cfg3_i, cfg2_i, cfg1_i, cfg0_i};
      three_wire_q <= spi_3wire_i;
    end
  end

  pin_xbar_enable_decode u_decode (
    .cfg0_i      (cfg_q[0]),
    .cfg1_i      (cfg_q[1]),
    .cfg2_i      (cfg_q[2]),
    .cfg3_i      (cfg_q[3]),
    .three_wire_i(three_wire_q),
    .en_o        (en)
  );

  pin_xbar_alloc #(.NUM_PINS(NUM_PINS)) u_alloc (
    .en_i      (en),
    .pin_code_o(pin_code_o)
  );

  pin_xbar_route #(.NUM_PINS(NUM_PINS)) u_route (
    .pin_code_i  (pin_code_o),
    .pad_in_i    (pad_in_i),
    .gpio_out_i  (gpio_out_i),
    .gpio_oe_i   (gpio_oe_i),
    .periph_out_i(periph_out_i),
    .periph_oe_i (periph_oe_i),
    .pin_out_o   (pin_out_o),
    .pin_oe_o    (pin_oe_o),
    .periph_in_o (periph_in_o)
  );

  assign gpio_in_o = pad_in_i;

  a_r2_uart0_pins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q[0][2] |-> (pin_code_o[0] == CODE_W'(F_TX0 + 1)) && (pin_code_o[1] == CODE_W'(F_RX0 + 1)));

  a_r7_idle_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_q[1][1] |-> periph_in_o[F_T0]);

  a_r8_gpio_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_code_o[0] == '0) |-> (pin_out_o[0] == gpio_out_i[0]) && (pin_oe_o[0] == gpio_oe_i[0]));

  a_r9_input_only_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_code_o[1] == CODE_W'(F_RX0 + 1)) |-> !pin_oe_o[1]);

  a_r13_all_gpio: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q == '0) |-> (pin_code_o == '0));

  if (NUM_PINS >= 4) begin : g_nss_chk
    a_r4_nss_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_q[0][1] && !cfg_q[0][2] && three_wire_q)
        |-> (pin_code_o[0] == CODE_W'(F_SCK + 1)) && (pin_code_o[3] != CODE_W'(F_NSS + 1)));
  end
endmodule

// File: tb/pin_xbar_bench.sv
`timescale 1ns/1ps
module pin_xbar_bench;
  localparam int NP  = 32;
  localparam int NP2 = 24;
  localparam int NF  = 33;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic [7:0] cfg0 = '0, cfg1 = '0, cfg2 = '0, cfg3 = '0;
  logic       w3 = 1'b0;
  logic [NP-1:0] pad_in = '1, gpio_out = '0, gpio_oe = '0;
  logic [NF-1:0] p_out = '0, p_oe = '0;

  logic [NP-1:0]       gpio_in, pin_out, pin_oe;
  logic [NF-1:0]       p_in, p_in24;
  logic [NP-1:0][5:0]  codes;
  logic [NP2-1:0]      gpio_in24, pin_out24, pin_oe24;
  logic [NP2-1:0][5:0] codes24;

  pin_xbar u_pin_xbar (
    .clk_i(clk), .rst_ni(rst_ni), .cfg0_i(cfg0), .cfg1_i(cfg1), .cfg2_i(cfg2),
    .cfg3_i(cfg3), .spi_3wire_i(w3), .pad_in_i(pad_in), .gpio_out_i(gpio_out),
    .gpio_oe_i(gpio_oe), .gpio_in_o(gpio_in), .periph_out_i(p_out),
    .periph_oe_i(p_oe), .periph_in_o(p_in), .pin_out_o(pin_out),
    .pin_oe_o(pin_oe), .pin_code_o(codes)
  );

  pin_xbar #(.NUM_PINS(NP2)) u_pin_xbar_p24 (
    .clk_i(clk), .rst_ni(rst_ni), .cfg0_i(cfg0), .cfg1_i(cfg1), .cfg2_i(cfg2),
    .cfg3_i(cfg3), .spi_3wire_i(w3), .pad_in_i(pad_in[NP2-1:0]),
    .gpio_out_i(gpio_out[NP2-1:0]), .gpio_oe_i(gpio_oe[NP2-1:0]),
    .gpio_in_o(gpio_in24), .periph_out_i(p_out), .periph_oe_i(p_oe),
    .periph_in_o(p_in24), .pin_out_o(pin_out24), .pin_oe_o(pin_oe24),
    .pin_code_o(codes24)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // entry: {w3, cfg3, cfg2, cfg1, cfg0, code pin0, pin1, pin2, pin3}
  localparam logic [56:0] VEC [12] = '{
    {1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 6'd0,  6'd0,  6'd0,  6'd0},   // R13 nothing enabled
    {1'b0, 8'h00, 8'h00, 8'h00, 8'h04, 6'd1,  6'd2,  6'd0,  6'd0},   // R2
    {1'b0, 8'h00, 8'h00, 8'h00, 8'h02, 6'd3,  6'd4,  6'd5,  6'd6},   // R3 SPI group
    {1'b1, 8'h00, 8'h00, 8'h00, 8'h02, 6'd3,  6'd4,  6'd5,  6'd0},   // R4
    {1'b1, 8'h00, 8'h00, 8'h00, 8'h03, 6'd3,  6'd4,  6'd5,  6'd7},   // R4 shift
    {1'b0, 8'h00, 8'h00, 8'h00, 8'h07, 6'd1,  6'd2,  6'd3,  6'd4},   // R1 order
    {1'b0, 8'h00, 8'h00, 8'h00, 8'h18, 6'd11, 6'd12, 6'd13, 6'd0},   // R6 count 3
    {1'b0, 8'h00, 8'h00, 8'h00, 8'h38, 6'd11, 6'd12, 6'd13, 6'd14},  // R6 count 7
    {1'b0, 8'h00, 8'h00, 8'h02, 8'h00, 6'd21, 6'd0,  6'd0,  6'd0},   // R5 T0
    {1'b0, 8'h08, 8'h04, 8'h00, 8'h00, 6'd9,  6'd10, 6'd20, 6'd0},   // R5 UART1 CP2
    {1'b0, 8'h04, 8'h01, 8'h00, 8'h00, 6'd32, 6'd33, 6'd0,  6'd0},   // R12 last codes
    {1'b0, 8'h00, 8'h00, 8'h81, 8'h80, 6'd18, 6'd19, 6'd31, 6'd0}    // R1 R5
  };

  // independent priority walk built from R1, R3..R6, R11
  function automatic logic [NP-1:0][5:0] ref_codes(input logic [32:0] c, input int npins);
    bit [NF-1:0] en;
    int n, pin;
    logic [NP-1:0][5:0] r;
    en = '0;
    en[0]  = c[2];  en[1]  = c[2];
    en[2]  = c[1];  en[3]  = c[1];  en[4] = c[1];  en[5] = c[1] & ~c[32];
    en[6]  = c[0];  en[7]  = c[0];
    en[8]  = c[18]; en[9]  = c[18];
    n = int'(c[5:3]);
    if (n > 6) n = 6;
    for (int k = 0; k < n; k++) en[10+k] = 1'b1;
    en[16] = c[6];  en[17] = c[7];  en[18] = c[8];  en[19] = c[27];
    en[20] = c[9];  en[21] = c[10]; en[22] = c[11]; en[23] = c[12];
    en[24] = c[13]; en[25] = c[14]; en[26] = c[24]; en[27] = c[25];
    en[28] = c[19]; en[29] = c[20]; en[30] = c[15]; en[31] = c[16];
    en[32] = c[26];
    r = '0;
    pin = 0;
    for (int f = 0; f < NF; f++)
      if (en[f]) begin
        if (pin < npins) r[pin] = 6'(f + 1);
        pin++;
      end
    return r;
  endfunction

  task automatic apply(input logic [32:0] c);
    {w3, cfg3, cfg2, cfg1, cfg0} = c;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cmp_all(input logic [32:0] c, input string req);
    logic [NP-1:0][5:0] e32, e24;
    bit ok24;
    e32 = ref_codes(c, NP);
    e24 = ref_codes(c, NP2);
    chk(codes == e32, req, codes, e32);
    ok24 = 1'b1;
    for (int p = 0; p < NP2; p++) if (codes24[p] != e24[p]) ok24 = 1'b0;
    chk(ok24, req, codes24, e24[NP2-1:0]);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R13: held in reset with an enable applied
    cfg0 = 8'h04;
    repeat (3) @(negedge clk);
    chk(codes == '0, "R13 reset", codes, 0);
    rst_ni = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(codes[0] == 6'd1, "R13 after reset", codes[0], 1);
    // R13: change visible only after the next edge
    cfg0 = 8'h02;
    #1;
    chk(codes[0] == 6'd1, "R13 before edge", codes[0], 1);
    @(posedge clk);
    @(negedge clk);
    chk(codes[0] == 6'd3, "R13 after edge", codes[0], 3);

    // table walk (R1 R2 R3 R4 R5 R6 R12)
    for (int i = 0; i < 12; i++) begin
      logic [32:0] c;
      logic [23:0] exp4;
      c    = VEC[i][56:24];
      exp4 = VEC[i][23:0];
      apply(c);
      chk({codes[0], codes[1], codes[2], codes[3]} == exp4, "R1 table", {codes[0], codes[1], codes[2], codes[3]}, exp4);
      cmp_all(c, "R1 table walk");
    end

    // R11: everything enabled
    apply({1'b0, 8'h0F, 8'h1D, 8'hFF, 8'hFF});
    pad_in = '0;
    #1;
    chk(codes[31] == 6'd32, "R11 last pin", codes[31], 32);
    chk(p_in[32] == 1'b1, "R11 dropped input", p_in[32], 1);
    chk(codes24[23] == 6'd24, "R11 p24 last pin", codes24[23], 24);
    chk(p_in24[24] == 1'b1, "R11 p24 dropped input", p_in24[24], 1);
    cmp_all({1'b0, 8'h0F, 8'h1D, 8'hFF, 8'hFF}, "R11 full");

    // R8: GPIO pass-through
    apply('0);
    gpio_out = 32'h5A3C_96E1;
    gpio_oe  = 32'hF00F_33CC;
    pad_in   = 32'hA5C3_0F96;
    #1;
    chk(pin_out == gpio_out, "R8 out", pin_out, gpio_out);
    chk(pin_oe == gpio_oe, "R8 oe", pin_oe, gpio_oe);
    chk(gpio_in == pad_in, "R8 in", gpio_in, pad_in);

    // R7: disabled input idles high
    pad_in = '0;
    #1;
    chk(p_in[20] == 1'b1, "R7 T0 idle", p_in[20], 1);

    // R9: UART0 output driven by peripheral, RX0 oe forced low
    apply({1'b0, 8'h00, 8'h00, 8'h00, 8'h04});
    p_out = '0; p_out[0] = 1'b1;
    p_oe  = '0; p_oe[0] = 1'b1; p_oe[1] = 1'b1;
    gpio_out = '0;
    gpio_oe  = '1;
    #1;
    chk(pin_out[0] == 1'b1 && pin_oe[0] == 1'b1, "R9 TX0 drive", {pin_out[0], pin_oe[0]}, 3);
    chk(pin_oe[1] == 1'b0, "R9 RX0 oe", pin_oe[1], 0);
    chk(pin_oe[2] == 1'b1, "R8 unclaimed pin2", pin_oe[2], 1);

    // R10: input routed from its pin
    pad_in = '1; pad_in[1] = 1'b0;
    #1;
    chk(p_in[1] == 1'b0, "R10 RX0 low", p_in[1], 0);
    pad_in[1] = 1'b1; pad_in[0] = 1'b0;
    #1;
    chk(p_in[1] == 1'b1, "R10 RX0 high", p_in[1], 1);

    // R1 random configurations
    for (int i = 0; i < 150; i++) begin
      logic [32:0] c;
      c = {1'($urandom), 32'($urandom)};
      apply(c);
      cmp_all(c, "R1 random");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule